// File: doc/BRIEF.md
# Quarter-Rate Debug Sample Buffer

This block moves a set of observed single-bit signals from a fast logic clock into a programmable debug region that runs at exactly one quarter of that rate. The quarter-rate clock is made inside the block from a free-running phase counter, so the two sides are locked together and no synchronizers are needed. Each observed bit is sampled on every fast cycle. After each group of four cycles the samples appear together on four parallel pins. There is no flow control, so every fast-cycle sample reaches the slow side exactly once.

A return path does the reverse for control signals. For each control signal the slow side presents four bits, and the block plays them back on the next four fast cycles, oldest first. Each observed signal also has a bypass select. When the select is set, the signal's live value is routed straight to the first of its four pins and the other three are driven low.

Top module: `dbgbuf_x4`

## Requirements
- R1: After reset the phase counter reads 0 in the first fast cycle and advances by one each fast cycle, wrapping from 3 to 0. `clk_slow_o` is low in phases 0 and 1 and high in phases 2 and 3.
- R2: For a signal i that is not bypassed, pin `obs_par_o[4*i+k]` carries the value `obs_i[i]` had in phase k of the last completed group. Pin k=0 is the oldest sample.
- R3: The parallel observe word changes only at the clock edge that ends phase 3, and it holds for the four fast cycles that follow.
- R4: Every fast-cycle sample is delivered. No group is skipped and no sample is repeated.
- R5: From reset until the first group of four samples has been captured, `obs_par_o` is all zero, whatever the bypass selects are.
- R6: While `byp_i[i]` is 1 and a group has been captured, `obs_par_o[4*i]` follows `obs_i[i]` with no register delay, and `obs_par_o[4*i+1]` through `obs_par_o[4*i+3]` are 0.
- R7: `ctl_par_i` is sampled at the edge that ends phase 3. During phase k of the next group, `ctl_o[j]` equals the sampled `ctl_par_i[4*j+k]`.
- R8: Until the first control group has been loaded, `ctl_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| obs_i | input | NUM_OBS | Observed fast-domain bits |
| byp_i | input | NUM_OBS | Bypass select for each observed bit |
| obs_par_o | output | 4*NUM_OBS | Parallel samples toward the slow side |
| ctl_par_i | input | 4*NUM_CTL | Parallel control bits from the slow side |
| ctl_o | output | NUM_CTL | Replayed control bits in the fast domain |
| clk_slow_o | output | 1 | Derived quarter-rate clock |

## Verification
The embedded properties assume that `ctl_par_i` comes from logic clocked by `clk_slow_o`. That means it is stable at the edge that ends phase 3. They also assume that reset is released cleanly, so the phase counter starts from 0. The bench drives every input just after a falling edge of the fast clock. It changes control words and bypass selects only at a group boundary, so the control input never moves near its sampling edge. A sweep over all 256 four-cycle patterns of two observed bits covers every ordering. The bypass selects are toggled throughout that sweep.

// File: rtl/dbgbuf_pkg.sv
package dbgbuf_pkg;
    localparam int unsigned RATIO   = 4;
    localparam int unsigned PHASE_W = $clog2(RATIO);
    typedef logic [PHASE_W-1:0] phase_t;
    localparam phase_t PHASE_LAST = phase_t'(RATIO - 1);
endpackage

// File: rtl/dbgbuf_phase.sv
module dbgbuf_phase
    import dbgbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase_o,
    output logic   last_o,
    output logic   primed_o,
    output logic   clk_slow_o
);
    typedef struct packed {
        phase_t phase;
        logic   primed;
        logic   slow;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.phase = st_q.phase + phase_t'(1);
        st_d.slow  = st_d.phase[PHASE_W-1];
        if (st_q.phase == PHASE_LAST) begin
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.phase;
    assign last_o     = (st_q.phase == PHASE_LAST);
    assign primed_o   = st_q.primed;
    assign clk_slow_o = st_q.slow;

    // R1: the counter steps by one each fast cycle
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_o == phase_t'($past(phase_o) + phase_t'(1)));
    // R1: the slow clock rises when the counter enters phase 2
    a_r1_slow_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_slow_o) |-> phase_o == phase_t'(2));
    // R5: once a group has been captured it stays captured
    a_r5_primed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        primed_o |=> primed_o);
endmodule

// File: rtl/dbgbuf_obs_lane.sv
module dbgbuf_obs_lane
    import dbgbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase_i,
    input  logic             last_i,
    input  logic             primed_i,
    input  logic             sample_i,
    input  logic             byp_i,
    output logic [RATIO-1:0] pins_o
);
    typedef struct packed {
        logic [RATIO-2:0] cap;
        logic [RATIO-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < RATIO - 1; k++) begin
            if (phase_i == phase_t'(k)) begin
                st_d.cap[k] = sample_i;
            end
        end
        if (last_i) begin
            st_d.hold = {sample_i, st_q.cap};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (byp_i) begin
            pins_o = {{(RATIO-1){1'b0}}, sample_i & primed_i};
        end else begin
            pins_o = st_q.hold;
        end
    end

    // R3: the held group only moves at the edge that ends the last phase
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(st_q.hold));
    // R5: nothing leaves the lane before the first group is complete
    a_r5_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_i |-> pins_o == '0);
    // R2: the newest pin takes the sample present at the last phase
    a_r2_newest_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !byp_i) |=> byp_i || pins_o[RATIO-1] == $past(sample_i));
endmodule

// File: rtl/dbgbuf_ctl_lane.sv
module dbgbuf_ctl_lane
    import dbgbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase_i,
    input  logic             last_i,
    input  logic             primed_i,
    input  logic [RATIO-1:0] par_i,
    output logic             bit_o
);
    typedef struct packed {
        logic [RATIO-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (last_i) begin
            st_d.hold = par_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.hold[phase_i];

    // R7: the first replayed bit is the oldest of the sampled word
    a_r7_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == phase_t'(0) && primed_i) |-> bit_o == $past(par_i[0]));
    // R8: the output stays low until a word has been loaded
    a_r8_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_i |-> !bit_o);
endmodule

// File: rtl/dbgbuf_x4.sv
module dbgbuf_x4
    import dbgbuf_pkg::*;
#(
    parameter int unsigned NUM_OBS = 8,
    parameter int unsigned NUM_CTL = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_OBS-1:0]       obs_i,
    input  logic [NUM_OBS-1:0]       byp_i,
    output logic [RATIO*NUM_OBS-1:0] obs_par_o,
    input  logic [RATIO*NUM_CTL-1:0] ctl_par_i,
    output logic [NUM_CTL-1:0]       ctl_o,
    output logic                     clk_slow_o
);
    phase_t phase;
    logic   last;
    logic   primed;

    dbgbuf_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .last_o     (last),
        .primed_o   (primed),
        .clk_slow_o (clk_slow_o)
    );

    for (genvar i = 0; i < NUM_OBS; i++) begin : g_obs
        dbgbuf_obs_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase_i  (phase),
            .last_i   (last),
            .primed_i (primed),
            .sample_i (obs_i[i]),
            .byp_i    (byp_i[i]),
            .pins_o   (obs_par_o[i*RATIO +: RATIO])
        );
    end

    for (genvar j = 0; j < NUM_CTL; j++) begin : g_ctl
        dbgbuf_ctl_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase_i  (phase),
            .last_i   (last),
            .primed_i (primed),
            .par_i    (ctl_par_i[j*RATIO +: RATIO]),
            .bit_o    (ctl_o[j])
        );
    end

    // R1: the derived clock is low for the first half of each group
    a_r1_slow_low_start: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == phase_t'(0)) |-> !clk_slow_o);
endmodule

// File: tb/tb_dbgbuf_x4.sv
module tb_dbgbuf_x4;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 2;
    localparam int NC = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NO-1:0]   obs_i = '0;
    logic [NO-1:0]   byp_i = '0;
    logic [4*NO-1:0] obs_par_o;
    logic [4*NC-1:0] ctl_par_i = '0;
    logic [NC-1:0]   ctl_o;
    logic            clk_slow_o;

    int checks = 0;
    int errors = 0;

    dbgbuf_x4 #(.NUM_OBS(NO), .NUM_CTL(NC)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .obs_i      (obs_i),
        .byp_i      (byp_i),
        .obs_par_o  (obs_par_o),
        .ctl_par_i  (ctl_par_i),
        .ctl_o      (ctl_o),
        .clk_slow_o (clk_slow_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4*NO-1:0] exp_par(input logic [4*NO-1:0] held,
            input logic [NO-1:0] b, input logic [NO-1:0] live, input logic pr);
        logic [4*NO-1:0] r;
        for (int i = 0; i < NO; i++) begin
            if (b[i]) r[i*4 +: 4] = {3'b000, live[i] & pr};
            else      r[i*4 +: 4] = held[i*4 +: 4];
        end
        return r;
    endfunction

    initial begin
        logic [4*NO-1:0] held;
        logic [4*NC-1:0] ctl_prev;
        logic [7:0]      pat;
        logic [7:0]      cpat;
        held = '0;
        ctl_prev = '0;
        repeat (3) @(negedge clk);
        check(32'(obs_par_o), 0, "R5 reset obs");
        check(32'(ctl_o), 0, "R8 reset ctl");
        check(32'(clk_slow_o), 0, "R1 reset slow clock");
        rst_n = 1'b1;
        for (int g = 0; g <= 256; g++) begin
            pat  = 8'(g);
            cpat = pat ^ 8'hA5;
            for (int p = 0; p < 4; p++) begin
                check(32'(clk_slow_o), 32'(p >= 2), "R1 slow clock phase");
                if (g == 0) begin
                    check(32'(obs_par_o), 0, "R5 before first group");
                    check(32'(ctl_o), 0, "R8 before first load");
                end else begin
                    check(32'(obs_par_o), 32'(exp_par(held, byp_i, obs_i, 1'b1)),
                          "R2 R3 R4 held group");
                    for (int i = 0; i < NO; i++) begin
                        if (byp_i[i]) check(32'(obs_par_o[i*4]), 32'(obs_i[i]), "R6 bypass live");
                    end
                    for (int j = 0; j < NC; j++) begin
                        check(32'(ctl_o[j]), 32'(ctl_prev[j*4+p]), "R7 control replay");
                    end
                end
                if (p == 0) begin
                    ctl_par_i = cpat;
                    byp_i = (g % 3 == 1) ? 2'(g >> 2) : 2'b00;
                end
                for (int i = 0; i < NO; i++) obs_i[i] = pat[p*NO + i];
                if (g == 0 && byp_i != 0) begin
                    #1 check(32'(obs_par_o), 0, "R5 bypass before first group");
                end
                @(negedge clk);
            end
            for (int i = 0; i < NO; i++) begin
                for (int p = 0; p < 4; p++) held[i*4+p] = pat[p*NO + i];
            end
            ctl_prev = cpat;
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule